// File: doc/BRIEF.md
# Runaway-Software Watchdog with Protected Count Mode

This block guards against software that has stopped running normally. A down-counter, CNT_W bits wide and 15 bits by default, loses one count per count tick. Software must reload it before it passes zero. If the counter is already at zero when a tick arrives, the block reloads the counter and acts: it either raises a sticky interrupt request or emits a one-clock reset pulse. To reload the counter, software writes 00h and then FFh to a kick register. Any other pattern of writes leaves the count alone.

In the normal mode, the tick comes from the CPU clock enable through a prescaler that divides by 16 or by 128. Counting pauses while the system reports stop or wait. Software can switch on a protected mode, and after that it cannot switch it off again. In the protected mode the tick is the low-speed oscillator enable, with no prescaler. The reload value is shorter, stop and wait are ignored, and every underflow produces a reset.

The register bus is a plain single-cycle write port with a combinational read mux. It has no handshake and no back-pressure, so every write strobe is taken in the cycle it is presented. Both clock sources are modelled as enables on one clock.

Top module: `runaway_watchdog`

## Requirements
- R1: After reset the counter reads all ones (2^CNT_W-1). The interrupt and reset outputs are low. The configuration register reads 0.
- R2: With protection off, the counter loses one count every 2^LO_LOG2 enabled CPU clock cycles when config bit0 is 0, and every 2^HI_LOG2 cycles when bit0 is 1. Underflow occurs on the tick that finds the counter at zero, so it comes reload+1 ticks after a reload. Underflow reloads the counter.
- R3: If auto_start is high, counting begins on the first clock after reset. If auto_start is low, the counter holds until any write to address 1.
- R4: A write of 00h to address 0, followed directly by a write of FFh to address 0, reloads the counter and clears the prescaler. If another value is written to address 0 in between, the sequence is cancelled. A lone FFh write has no effect.
- R5: With protection off, a high stop_mode or wait_mode freezes both the counter and the prescaler.
- R6: Writing 1 to config bit1 turns on protection. In protected mode the counter loses one count per cycle in which lsosc_en is high. cpu_clk_en, stop_mode and wait_mode are ignored, and the reload value is PROT_RELOAD.
- R7: With protection off, an underflow raises the interrupt when address 3 bit0 is 0 and pulses the reset output when that bit is 1. With protection on, an underflow always pulses the reset output.
- R8: The interrupt stays high until a cycle with irq_ack high clears it. The reset output is high for exactly one cycle per underflow.
- R9: Once protection is on, writes to address 2 are ignored until the next reset.
- R10: A read of address 0 returns the counter, address 2 returns {prot, slow} in bits 1:0, address 3 returns the reset-select bit in bit0, and address 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_clk_en | input | 1 | CPU clock enable, feeds the prescaler |
| lsosc_en | input | 1 | Low-speed oscillator tick enable |
| stop_mode | input | 1 | System is in stop state |
| wait_mode | input | 1 | System is in wait state |
| auto_start | input | 1 | 1: count from reset; 0: wait for a start write |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 kick, 1 start, 2 config, 3 system control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| irq_ack | input | 1 | Clears the interrupt request |
| wdt_irq | output | 1 | Sticky watchdog interrupt request |
| wdt_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The bench builds the block with CNT_W=6, PROT_RELOAD=15 and prescaler divides of 4 and 8. With these values a normal-mode underflow takes 256 or 512 cycles and a protected underflow takes 16 ticks. Within a short run the bench can therefore see repeated underflows, both divide ratios, both underflow actions, halts during stop and wait, and the reload to the shortened protected value. Expected underflow cycles are derived from those ratios and are checked to the exact clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_KICK = 2'd0,
    REG_GO   = 2'd1,
    REG_CFG  = 2'd2,
    REG_SYS  = 2'd3
  } wdt_reg_e;

  localparam logic [7:0] KICK_ARM  = 8'h00;
  localparam logic [7:0] KICK_FIRE = 8'hFF;

  typedef struct packed {
    logic prot;
    logic slow;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int LO_LOG2 = 4,
  parameter int HI_LOG2 = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic sel_slow,
  output logic tick
);
  logic [HI_LOG2-1:0] pcnt;
  logic               wrap_lo;
  logic               wrap_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (adv) pcnt <= pcnt + 1'b1;
  end

  assign wrap_lo = &pcnt[LO_LOG2-1:0];
  assign wrap_hi = &pcnt;
  assign tick    = adv && !clr && (sel_slow ? wrap_hi : wrap_lo);
endmodule

// File: rtl/wdt_kick_seq.sv
module wdt_kick_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       reload
);
  logic armed;

  assign reload = wr && armed && (wdata == KICK_FIRE);

  always_ff @(posedge clk) begin
    if (!rst_n)  armed <= 1'b0;
    else if (wr) armed <= (wdata == KICK_ARM);
  end
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] RST_VAL = '1;

  assign underflow = tick && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= RST_VAL;
    else if (load)      cnt <= reload_val;
    else if (underflow) cnt <= reload_val;
    else if (tick)      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/runaway_watchdog.sv
module runaway_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int PROT_RELOAD = 4095,
  parameter int LO_LOG2     = 4,
  parameter int HI_LOG2     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_clk_en,
  input  logic             lsosc_en,
  input  logic             stop_mode,
  input  logic             wait_mode,
  input  logic             auto_start,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             irq_ack,
  output logic             wdt_irq,
  output logic             wdt_rst
);
  localparam logic [CNT_W-1:0] FULL_VAL = '1;
  localparam logic [CNT_W-1:0] PROT_VAL = CNT_W'(PROT_RELOAD);

  wdt_reg_e         sel_reg;
  wdt_cfg_t         cfg_q;
  logic             started_q;
  logic             rst_sel_q;
  logic             irq_q;
  logic             rst_q;
  logic             prot_on;
  logic             wr_kick, wr_go, wr_cfg, wr_sys;
  logic             run, adv, pre_tick, tick, kick_reload, uflow;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_q;

  assign sel_reg = wdt_reg_e'(bus_addr);
  assign wr_kick = bus_we && (sel_reg == REG_KICK);
  assign wr_go   = bus_we && (sel_reg == REG_GO);
  assign wr_cfg  = bus_we && (sel_reg == REG_CFG);
  assign wr_sys  = bus_we && (sel_reg == REG_SYS);
  assign prot_on = cfg_q.prot;

  // Count gating: protection ignores the low-power states
  assign run        = (started_q || auto_start) && (prot_on || !(stop_mode || wait_mode));
  assign adv        = run && !prot_on && cpu_clk_en;
  assign tick       = prot_on ? (run && lsosc_en) : pre_tick;
  assign reload_val = prot_on ? PROT_VAL : FULL_VAL;

  wdt_prescaler #(.LO_LOG2(LO_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(kick_reload), .adv(adv),
    .sel_slow(cfg_q.slow), .tick(pre_tick)
  );

  wdt_kick_seq u_kick (
    .clk(clk), .rst_n(rst_n), .wr(wr_kick), .wdata(bus_wdata),
    .reload(kick_reload)
  );

  wdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(kick_reload), .tick(tick),
    .reload_val(reload_val), .cnt(cnt_q), .underflow(uflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      cfg_q     <= '0;
      rst_sel_q <= 1'b0;
    end else begin
      if (wr_go) started_q <= 1'b1;
      if (wr_cfg && !prot_on) cfg_q <= wdt_cfg_t'(bus_wdata[1:0]);
      if (wr_sys) rst_sel_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= uflow && (prot_on || rst_sel_q);
      if (uflow && !prot_on && !rst_sel_q) irq_q <= 1'b1;
      else if (irq_ack)                    irq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel_reg)
      REG_KICK: bus_rdata = cnt_q;
      REG_CFG:  bus_rdata[1:0] = cfg_q;
      REG_SYS:  bus_rdata[0] = rst_sel_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign wdt_irq = irq_q;
  assign wdt_rst = rst_q;
endmodule

module wdt_guard_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             prot,
  input logic             stop_mode,
  input logic             wait_mode,
  input logic             lsosc_en,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic             irq_ack,
  input logic             wdt_irq,
  input logic             wdt_rst
);
  // R8
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_irq && !irq_ack) |=> wdt_irq);

  // R7
  irq_rst_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> !wdt_rst);

  // R9
  prot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> prot);

  // R5
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot && (stop_mode || wait_mode) && !(bus_we && bus_addr == 2'd0)) |=> $stable(count));

  // R6
  prot_osc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot && !lsosc_en && !(bus_we && bus_addr == 2'd0)) |=> $stable(count));
endmodule

bind runaway_watchdog wdt_guard_chk #(.CNT_W(CNT_W)) u_guard (
  .clk(clk), .rst_n(rst_n), .count(cnt_q), .prot(prot_on),
  .stop_mode(stop_mode), .wait_mode(wait_mode), .lsosc_en(lsosc_en),
  .bus_we(bus_we), .bus_addr(bus_addr), .irq_ack(irq_ack),
  .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
);

// File: tb/sim_runaway_watchdog.sv
module sim_runaway_watchdog;
  localparam int CW  = 6;
  localparam int PRV = 15;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cpu_clk_en = 1'b1, lsosc_en = 1'b0;
  logic          stop_mode = 1'b0, wait_mode = 1'b0, auto_start = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [CW-1:0] bus_rdata;
  logic          irq_ack = 1'b0;
  logic          wdt_irq, wdt_rst;

  runaway_watchdog #(.CNT_W(CW), .PROT_RELOAD(PRV), .LO_LOG2(2), .HI_LOG2(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en), .lsosc_en(lsosc_en),
    .stop_mode(stop_mode), .wait_mode(wait_mode), .auto_start(auto_start),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
  );

  int pcyc = 0;
  always @(posedge clk) pcyc <= pcyc + 1;

  int n_chk = 0, n_bad = 0;
  int P, W, S, v;
  int    q_cyc[$];
  bit    q_rst[$];
  string q_req[$];

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // Monitor: pops the scoreboard on every underflow action
  bit prev_irq = 1'b0, prev_rst = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wdt_rst && prev_rst) chk(1'b0, "R8", "reset pulse width", 2, 1);
      if (wdt_rst || (wdt_irq && !prev_irq)) begin
        if (q_cyc.size() == 0) chk(1'b0, "R7", "unexpected underflow at cycle", pcyc, -1);
        else begin
          int  ec;
          bit  er;
          string rq;
          ec = q_cyc.pop_front(); er = q_rst.pop_front(); rq = q_req.pop_front();
          chk(er == wdt_rst, rq, "action kind (1=reset)", int'(wdt_rst), int'(er));
          chk(ec == pcyc, rq, "underflow cycle", pcyc, ec);
        end
      end
      prev_irq = wdt_irq;
      prev_rst = wdt_rst;
    end else begin
      prev_irq = 1'b0;
      prev_rst = 1'b0;
    end
  end

  task automatic expect_ev(bit is_rst, int cyc, string req);
    q_cyc.push_back(cyc); q_rst.push_back(is_rst); q_req.push_back(req);
  endtask

  task automatic do_reset(bit auto_go);
    @(negedge clk);
    rst_n = 1'b0; auto_start = auto_go; cpu_clk_en = 1'b1; lsosc_en = 1'b0;
    stop_mode = 1'b0; wait_mode = 1'b0; bus_we = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    P = pcyc;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, output int at);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; at = pcyc;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_now(logic [1:0] a, output int val);
    bus_addr = a;
    #1 val = int'(bus_rdata);
  endtask

  task automatic wait_until(int c);
    while (pcyc < c) @(negedge clk);
  endtask

  task automatic drain();
    wait (q_cyc.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    int dummy;
    // R1 reset state
    do_reset(1'b0);
    rd_now(2'd0, v); chk(v == FULL, "R1", "counter after reset", v, FULL);
    rd_now(2'd2, v); chk(v == 0, "R1", "config after reset", v, 0);
    chk(!wdt_irq && !wdt_rst, "R1", "outputs after reset", int'({wdt_irq, wdt_rst}), 0);

    // R2 fast divide, R3 auto start, R7 interrupt action, R8 sticky irq
    do_reset(1'b1);
    expect_ev(1'b0, P + 256, "R2");
    expect_ev(1'b0, P + 512, "R2");
    wait (q_cyc.size() == 1);
    repeat (5) @(negedge clk);
    chk(wdt_irq == 1'b1, "R8", "irq held before ack", int'(wdt_irq), 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(wdt_irq == 1'b0, "R8", "irq after ack", int'(wdt_irq), 0);
    drain();

    // R3 manual start, R2 slow divide, R7 reset action, R10 readback
    do_reset(1'b0);
    wr(2'd2, 8'h01, dummy);
    wr(2'd3, 8'h01, dummy);
    repeat (20) @(negedge clk);
    rd_now(2'd0, v); chk(v == FULL, "R3", "counter before start write", v, FULL);
    rd_now(2'd2, v); chk(v == 1, "R10", "config readback", v, 1);
    rd_now(2'd3, v); chk(v == 1, "R10", "system control readback", v, 1);
    rd_now(2'd1, v); chk(v == 0, "R10", "start address readback", v, 0);
    wr(2'd1, 8'h5A, S);
    expect_ev(1'b1, S + 513, "R7");
    drain();

    // R4 refresh sequence rules
    do_reset(1'b1);
    wait_until(P + 40);
    wr(2'd0, 8'h00, dummy);
    wr(2'd0, 8'h55, dummy);
    wr(2'd0, 8'hFF, dummy);
    rd_now(2'd0, v); chk(v == FULL - (pcyc - P) / 4, "R4", "count after cancelled refresh", v, FULL - (pcyc - P) / 4);
    wr(2'd0, 8'hFF, dummy);
    rd_now(2'd0, v); chk(v == FULL - (pcyc - P) / 4, "R4", "count after lone FFh", v, FULL - (pcyc - P) / 4);
    wr(2'd0, 8'h00, dummy);
    wr(2'd0, 8'hFF, W);
    expect_ev(1'b0, W + 257, "R4");
    drain();

    // R5 stop and wait halt counting
    do_reset(1'b1);
    expect_ev(1'b0, P + 296, "R5");
    wait_until(P + 20); wait_mode = 1'b1;
    wait_until(P + 30);
    rd_now(2'd0, v); chk(v == FULL - 5, "R5", "counter frozen in wait", v, FULL - 5);
    wait_until(P + 40); wait_mode = 1'b0;
    wait_until(P + 100); stop_mode = 1'b1;
    wait_until(P + 120); stop_mode = 1'b0;
    drain();

    // R6 protected source, R7 forced reset, R9 lock
    do_reset(1'b0);
    cpu_clk_en = 1'b0; lsosc_en = 1'b1; stop_mode = 1'b1;
    wr(2'd2, 8'h02, dummy);
    wr(2'd1, 8'h00, dummy);
    wr(2'd0, 8'h00, dummy);
    wr(2'd0, 8'hFF, W);
    expect_ev(1'b1, W + 17, "R6");
    expect_ev(1'b1, W + 33, "R7");
    rd_now(2'd0, v); chk(v == PRV, "R6", "protected reload value", v, PRV);
    wr(2'd2, 8'h00, dummy);
    rd_now(2'd2, v); chk(v == 2, "R9", "config locked", v, 2);
    drain();
    do_reset(1'b0);

    chk(q_cyc.size() == 0, "R7", "events left unseen", q_cyc.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", pcyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule